// File: doc/BRIEF.md
# Digital I/O Card Register Bank

This block holds the host-visible byte registers of a digital I/O card. Software reaches it over a plain byte-wide bus: a 4-bit byte offset, a write strobe, write data and registered read data. Three byte latches drive 24 switched outputs, and a fourth latch drives an 8-bit logic-level port. The 24 isolated input pins and the 8 logic-level pins can be read back once they have passed through a synchronizer.

One control bit turns the whole logic-level port around as a group. When the bit is set the port drives its latch onto the pins. When it is clear the port's driver is off and the pins act as inputs. The highest offset has a different meaning for each direction: writing it resets the board for one cycle, and reading it returns the present level of the card's interrupt request line. The reset pulse is also brought out so the companion change-of-state block can clear its enable and status state. Offsets 8 to 11 and 14 belong to that companion block. Here they read as zero and ignore writes.

Top module: `dio_regbank`

## Requirements
- R1: After the hardware reset, sw_out, lvl_out, lvl_oe, soft_rst_o and bus_rdata are all zero. The logic-level port therefore starts as an input.
- R2: A write to offset 0, 1 or 2 loads switched outputs 7..0, 15..8 or 23..16 in that order, at the write edge. A read of the same offset returns the latched byte.
- R3: A write to offset 3 loads the logic-level output latch (lvl_out). Offset 3 reads the latch back.
- R4: Bit 1 of the control byte at offset 12 selects output mode, and lvl_oe follows it. Offset 12 reads back with the mode in bit 1 and zeros in all other bits.
- R5: bus_rdata is registered. It shows the register addressed at a clock edge from that edge on, and holds the previous value until then.
- R6: Offsets 4, 5 and 6 return isolated inputs 7..0, 15..8 and 23..16. Offset 7 returns the logic-level pins. A pin change applied before edge n first shows on bus_rdata after edge n+2, with the offset held.
- R7: Writes to offsets 4 to 11, 13 and 14 change no output and no readable register.
- R8: Offsets 8 to 11, 13 and 14 read as zero.
- R9: A read of offset 15 returns the irq_level input in bit 0 and zeros in bits 7..1.
- R10: A write to offset 15 raises soft_rst_o for exactly one cycle, beginning at the write edge. At the edge that ends the pulse, all output latches and the control byte clear.
- R11: A write presented while soft_rst_o is high is lost, because the reset takes priority. A second write to offset 15 during the pulse does not lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | 4 | Byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| iso_in | input | 24 | Isolated input pins, asynchronous |
| lvl_pin_in | input | 8 | Logic-level pin levels, asynchronous |
| irq_level | input | 1 | Present level of the card interrupt request |
| sw_out | output | 24 | Switched output drive |
| lvl_out | output | 8 | Logic-level port output value |
| lvl_oe | output | 1 | Logic-level port driver enable |
| soft_rst_o | output | 1 | One-cycle software reset pulse for the companion block |

## Verification
Some properties are checked by the assertions on every cycle:
- a write to offset 15 starts a pulse that is exactly one cycle long and leaves every output cleared;
- byte writes land in the addressed latch;
- writes to inert offsets leave all outputs stable;
- the reserved offset and the interrupt-level offset read correctly one cycle after they are addressed.

Other properties can only be shown by the bench's scenarios:
- the full read map after every write of a swept set of data patterns;
- the two-cycle input synchronizer latency;
- the registered read latency when the offset changes;
- writes lost inside the reset pulse.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int SW_BYTES = 3;
    localparam int SW_W     = SW_BYTES * BYTE_W;
    localparam int IDX_W    = 2;

    localparam logic [ADDR_W-1:0] OFS_SW_FIRST  = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_LVL_LATCH = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_ISO_FIRST = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_LVL_PINS  = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_CTRL      = 4'd12;
    localparam logic [ADDR_W-1:0] OFS_IRQ_RST   = 4'd15;
    localparam int               CTRL_OE_BIT   = 1;

    typedef enum logic [2:0] {
        K_SW,
        K_LVL_LATCH,
        K_ISO,
        K_LVL_PINS,
        K_CTRL,
        K_IRQ_RST,
        K_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } reg_sel_t;

    function automatic reg_sel_t dio_decode(logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.kind = K_NONE;
        s.idx  = a[IDX_W-1:0];
        if (a >= OFS_SW_FIRST && a < OFS_SW_FIRST + 4'(SW_BYTES))
            s.kind = K_SW;
        else if (a == OFS_LVL_LATCH)
            s.kind = K_LVL_LATCH;
        else if (a >= OFS_ISO_FIRST && a < OFS_ISO_FIRST + 4'(SW_BYTES))
            s.kind = K_ISO;
        else if (a == OFS_LVL_PINS)
            s.kind = K_LVL_PINS;
        else if (a == OFS_CTRL)
            s.kind = K_CTRL;
        else if (a == OFS_IRQ_RST)
            s.kind = K_IRQ_RST;
        if (s.kind == K_ISO)
            s.idx = IDX_W'(a - OFS_ISO_FIRST);
        else if (s.kind == K_SW)
            s.idx = IDX_W'(a - OFS_SW_FIRST);
        return s;
    endfunction

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= d;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dio_wr_regs.sv
module dio_wr_regs
    import dio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [SW_W-1:0]   sw_q,
    output logic [BYTE_W-1:0] lvl_q,
    output logic              oe_q,
    output logic              soft_q
);
    reg_sel_t sel;
    logic     clr;

    assign sel = dio_decode(addr);
    assign clr = rst || soft_q;

    always_ff @(posedge clk) begin
        if (rst)
            soft_q <= 1'b0;
        else
            soft_q <= wr_en && (sel.kind == K_IRQ_RST) && !soft_q;
    end

    generate
        for (genvar g = 0; g < SW_BYTES; g++) begin : g_sw_byte
            always_ff @(posedge clk) begin
                if (clr)
                    sw_q[g*BYTE_W +: BYTE_W] <= '0;
                else if (wr_en && sel.kind == K_SW && sel.idx == IDX_W'(g))
                    sw_q[g*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) begin
            lvl_q <= '0;
            oe_q  <= 1'b0;
        end else if (wr_en) begin
            if (sel.kind == K_LVL_LATCH)
                lvl_q <= wdata;
            if (sel.kind == K_CTRL)
                oe_q <= wdata[CTRL_OE_BIT];
        end
    end
endmodule

// File: rtl/dio_rd_mux.sv
module dio_rd_mux
    import dio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SW_W-1:0]   sw_q,
    input  logic [BYTE_W-1:0] lvl_q,
    input  logic              oe_q,
    input  logic [SW_W-1:0]   iso_s,
    input  logic [BYTE_W-1:0] pins_s,
    input  logic              irq_level,
    output logic [BYTE_W-1:0] rdata
);
    localparam int BASE_W = $clog2(SW_W);

    reg_sel_t          sel;
    logic [BYTE_W-1:0] nxt;
    logic [BASE_W-1:0] base;

    assign sel  = dio_decode(addr);
    assign base = BASE_W'(sel.idx) * BASE_W'(BYTE_W);

    always_comb begin
        nxt = '0;
        case (sel.kind)
            K_SW:        nxt = sw_q[base +: BYTE_W];
            K_LVL_LATCH: nxt = lvl_q;
            K_ISO:       nxt = iso_s[base +: BYTE_W];
            K_LVL_PINS:  nxt = pins_s;
            K_CTRL:      nxt[CTRL_OE_BIT] = oe_q;
            K_IRQ_RST:   nxt[0] = irq_level;
            default:     nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= nxt;
    end
endmodule

// File: rtl/dio_regbank.sv
module dio_regbank
    import dio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [SW_W-1:0]   iso_in,
    input  logic [BYTE_W-1:0] lvl_pin_in,
    input  logic              irq_level,
    output logic [SW_W-1:0]   sw_out,
    output logic [BYTE_W-1:0] lvl_out,
    output logic              lvl_oe,
    output logic              soft_rst_o
);
    logic [SW_W-1:0]   iso_s;
    logic [BYTE_W-1:0] pins_s;

    dio_sync #(.W(SW_W), .STAGES(SYNC_STAGES)) i_sync_iso (
        .clk(clk), .rst(rst), .d(iso_in), .q(iso_s)
    );

    dio_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES)) i_sync_pins (
        .clk(clk), .rst(rst), .d(lvl_pin_in), .q(pins_s)
    );

    dio_wr_regs i_wr (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .sw_q(sw_out), .lvl_q(lvl_out),
        .oe_q(lvl_oe), .soft_q(soft_rst_o)
    );

    dio_rd_mux i_rd (
        .clk(clk), .rst(rst), .addr(bus_addr), .sw_q(sw_out),
        .lvl_q(lvl_out), .oe_q(lvl_oe), .iso_s(iso_s), .pins_s(pins_s),
        .irq_level(irq_level), .rdata(bus_rdata)
    );
endmodule

// File: rtl/dio_regbank_chk.sv
module dio_regbank_chk
    import dio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic [SW_W-1:0]   iso_in,
    input logic [BYTE_W-1:0] lvl_pin_in,
    input logic              irq_level,
    input logic [SW_W-1:0]   sw_out,
    input logic [BYTE_W-1:0] lvl_out,
    input logic              lvl_oe,
    input logic              soft_rst_o
);
    logic inert_wr;
    assign inert_wr = bus_wr && !soft_rst_o &&
                      ((bus_addr >= 4'd4 && bus_addr <= 4'd11) ||
                       bus_addr == 4'd13 || bus_addr == 4'd14);

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
        soft_rst_o |=> !soft_rst_o);

    p_pulse_start_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'd15 && !soft_rst_o) |=> soft_rst_o);

    p_pulse_clears_r10: assert property (@(posedge clk) disable iff (rst)
        soft_rst_o |=> (sw_out == '0 && lvl_out == '0 && !lvl_oe));

    p_sw_byte0_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'd0 && !soft_rst_o) |=>
            sw_out[7:0] == $past(bus_wdata));

    p_inert_write_r7: assert property (@(posedge clk) disable iff (rst)
        inert_wr |=> ($stable(sw_out) && $stable(lvl_out) && $stable(lvl_oe)));

    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 4'd13) |=> bus_rdata == '0);

    p_irq_read_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 4'd15) |=> bus_rdata == {7'b0, $past(irq_level)});
endmodule

bind dio_regbank dio_regbank_chk i_chk (.*);

// File: tb/test_dio_regbank.sv
module test_dio_regbank;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [23:0] iso_in;
    logic [7:0]  lvl_pin_in;
    logic        irq_level;
    logic [23:0] sw_out;
    logic [7:0]  lvl_out;
    logic        lvl_oe;
    logic        soft_rst_o;

    int nvec  = 0;
    int nfail = 0;
    logic [7:0] exp_sw [3];
    logic [7:0] exp_lvl;
    logic       exp_oe;

    always #2 clk = ~clk;

    dio_regbank i_dio_regbank (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(int a);
        case (a)
            0, 1, 2: return exp_sw[a];
            3:       return exp_lvl;
            4, 5, 6: return iso_in[(a-4)*8 +: 8];
            7:       return lvl_pin_in;
            12:      return {6'b0, exp_oe, 1'b0};
            15:      return {7'b0, irq_level};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(int a);
        if (a < 3) return "R2";
        if (a == 3) return "R3";
        if (a < 8) return "R6";
        if (a == 12) return "R4";
        if (a == 15) return "R9";
        return "R8";
    endfunction

    task automatic bus_write(int a, logic [7:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(int a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = 4'(a);
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic check_outputs(string tag);
        check(tag, sw_out, {exp_sw[2], exp_sw[1], exp_sw[0]});
        check(tag, lvl_out, exp_lvl);
        check(tag, lvl_oe, exp_oe);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        logic [7:0] rd;
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        iso_in = 24'h3C96E1; lvl_pin_in = 8'h5B; irq_level = 1'b1;
        for (int i = 0; i < 3; i++) exp_sw[i] = 8'h00;
        exp_lvl = 8'h00; exp_oe = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", sw_out, 24'h0);
        check("R1", lvl_out, 8'h0);
        check("R1", lvl_oe, 1'b0);
        check("R1", soft_rst_o, 1'b0);
        check("R1", bus_rdata, 8'h0);
        repeat (3) @(negedge clk);

        // R2 R3 R4 R7 R8 R9 R6: sweep of writes to every offset but 15
        for (int a = 0; a < 15; a++) begin
            for (int p = 0; p < 6; p++) begin
                bus_write(a, pats[p] ^ 8'(a * 17));
                case (a)
                    0, 1, 2: exp_sw[a] = pats[p] ^ 8'(a * 17);
                    3:       exp_lvl = pats[p] ^ 8'(a * 17);
                    12:      exp_oe = pats[p][1] ^ 1'(((a * 17) >> 1) & 1);
                    default: ;
                endcase
                check_outputs((a < 3) ? "R2" : (a == 3) ? "R3" : (a == 12) ? "R4" : "R7");
                for (int r = 0; r < 16; r++) begin
                    bus_read(r, rd);
                    check(rd_tag(r), rd, model_rd(r));
                end
            end
        end

        // R4: output mode set then clear
        bus_write(12, 8'h02); exp_oe = 1'b1;
        check("R4", lvl_oe, 1'b1);
        bus_write(12, 8'hFD); exp_oe = 1'b0;
        check("R4", lvl_oe, 1'b0);
        bus_read(12, rd); check("R4", rd, 8'h00);

        // R9: interrupt level low
        irq_level = 1'b0;
        bus_read(15, rd); check("R9", rd, 8'h00);
        irq_level = 1'b1;

        // R5: read data holds until the edge after the offset changes
        bus_write(0, 8'h11); exp_sw[0] = 8'h11;
        bus_write(1, 8'h22); exp_sw[1] = 8'h22;
        bus_read(0, rd); check("R5", rd, 8'h11);
        @(negedge clk); bus_addr = 4'd1; #1;
        check("R5", bus_rdata, 8'h11);
        @(negedge clk);
        check("R5", bus_rdata, 8'h22);

        // R6: synchronizer latency with offset held
        bus_read(4, rd); check("R6", rd, 8'hE1);
        @(negedge clk); iso_in[7:0] = 8'h0F;
        @(negedge clk); check("R6", bus_rdata, 8'hE1);
        @(negedge clk); check("R6", bus_rdata, 8'hE1);
        @(negedge clk); check("R6", bus_rdata, 8'h0F);
        bus_read(7, rd); check("R6", rd, 8'h5B);
        lvl_pin_in = 8'hC3;
        repeat (3) @(negedge clk);
        check("R6", bus_rdata, 8'hC3);

        // R10: software reset pulse
        bus_write(2, 8'h99); bus_write(3, 8'h77); bus_write(12, 8'h02);
        @(negedge clk);
        bus_addr = 4'd15; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10", soft_rst_o, 1'b1);
        check("R10", sw_out, {8'h99, 8'h22, 8'h11});
        @(negedge clk);
        check("R10", soft_rst_o, 1'b0);
        check("R10", sw_out, 24'h0);
        check("R10", lvl_out, 8'h0);
        check("R10", lvl_oe, 1'b0);
        for (int i = 0; i < 3; i++) exp_sw[i] = 8'h00;
        exp_lvl = 8'h00; exp_oe = 1'b0;
        bus_read(12, rd); check("R10", rd, 8'h00);

        // R11: write during pulse is lost
        @(negedge clk);
        bus_addr = 4'd15; bus_wr = 1'b1;
        @(negedge clk);
        check("R11", soft_rst_o, 1'b1);
        bus_addr = 4'd0; bus_wdata = 8'h77;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R11", soft_rst_o, 1'b0);
        check("R11", sw_out, 24'h0);

        // R11: second write to offset 15 during pulse does not extend it
        bus_write(3, 8'h3A);
        @(negedge clk);
        bus_addr = 4'd15; bus_wr = 1'b1;
        @(negedge clk);
        check("R11", soft_rst_o, 1'b1);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R11", soft_rst_o, 1'b0);
        check("R11", lvl_out, 8'h00);
        @(negedge clk);
        check("R11", soft_rst_o, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule